// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns characters into asynchronous serial frames on a single output line. It takes one character at a time from an upstream queue through a valid/ready handshake. Each frame holds a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. Every bit lasts a fixed number of ticks of an external oversampling strobe, which is sixteen by default. The strobe is produced outside the block, and so is the character storage.

Line options are plain inputs. The block reads them once, when a frame starts, and holds them for that whole frame. The options are the data width, parity enable, even or odd parity, stick parity, two stop bits, and a break request that pulls the line low. A frame starts only when several conditions hold together: both enables are high, no break is requested, the clear-to-send input allows it when flow control is on, and the oversampling strobe fires. Once a frame has begun, it always finishes, even if the enables are dropped or a break is requested. The busy output shows either pending upstream data or a frame on the wire.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame is a start bit at 0, then the data bits LSB first, then the parity bit if enabled, then the stop bits at 1. Each bit holds for OVERSAMPLE strobe ticks, and the start bit appears in the cycle after the accepting clock edge.
- R2: The width code `wlen` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3.
- R3: With `par_en`=1 and `par_stick`=0, the parity bit makes the count of ones over data and parity even when `par_even`=1, and odd when `par_even`=0.
- R4: With `par_en`=1 and `par_stick`=1, the parity bit is 1 when `par_even`=0 and 0 when `par_even`=1. With `par_en`=0, stick parity adds no bit.
- R5: With `stop2`=1, the frame ends with two stop bits; otherwise it ends with one.
- R6: When `brk`=1, the frame in progress completes unchanged. After that the line goes to 0 and stays there, and no new character is accepted.
- R7: Dropping `en_global` or `en_tx` during a frame does not cut it short. While either enable is low, no new frame starts.
- R8: `busy` is 1 whenever `ch_valid`=1, even when the block is disabled. It is also 1 while a frame is on the line, and it drops once the last stop bit has ended.
- R9: With `cts_flow_en`=1, a frame starts only while `cts`=1. With `cts_flow_en`=0, `cts` is ignored.
- R10: The line is 1 after reset and whenever there is no frame and no break.
- R11: `ch_ready` is 1 only in a strobe cycle where a start is permitted and `ch_valid`=1. Exactly one character is taken per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling strobe, one cycle wide |
| en_global | input | 1 | Block enable |
| en_tx | input | 1 | Transmit enable |
| cts_flow_en | input | 1 | Gate frame starts on cts |
| cts | input | 1 | Clear to send, active high |
| wlen | input | 2 | Data width code (0..3 means 5..8 bits) |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Stick parity select |
| stop2 | input | 1 | Two stop bits |
| brk | input | 1 | Break request |
| ch_valid | input | 1 | Upstream character available |
| ch_data | input | 8 | Upstream character |
| ch_ready | output | 1 | Character taken at this edge |
| txd | output | 1 | Serial line |
| busy | output | 1 | Data pending or frame on the line |

## Verification
The bench sends a frame for every combination of width code, parity enable, parity sense, stick parity and stop count. It samples each bit at its centre, so a wrong bit order, an inverted parity sense or an extra or missing stop bit shows up as a wrong level at a specific bit. It drops an enable and raises a break partway through a frame. A design that aborted the frame would produce a short or low stop bit, and one that ignored the break would keep the line high afterwards. It holds data pending while disabled or while `cts` is low and watches for a start, which catches a design that starts regardless of the enables or flow control, or that lowers `busy` when it should not.

// File: rtl/uart_frame_tx_pkg.sv
`timescale 1ns/1ps
package uart_frame_tx_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned MIN_DATA_W = 5;
  localparam int unsigned FRAME_W    = 1 + DATA_W + 1 + 2;
  localparam int unsigned LEN_W      = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       stop2;
  } line_cfg_t;
endpackage

// File: rtl/uart_frame_tx_framer.sv
`timescale 1ns/1ps
module uart_frame_tx_framer
  import uart_frame_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data,
  input  line_cfg_t          cfg,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);
  int unsigned nd;
  logic        par_acc;
  logic        pbit;

  // frame bit 0 is the start bit; unused upper positions stay at the stop level
  always_comb begin
    nd      = MIN_DATA_W + int'(cfg.wlen);
    par_acc = 1'b0;
    frame   = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) begin
        par_acc      = par_acc ^ data[i];
        frame[i + 1] = data[i];
      end
    end
    if (cfg.par_stick)
      pbit = ~cfg.par_even;
    else
      pbit = cfg.par_even ? par_acc : ~par_acc;
    if (cfg.par_en)
      frame[nd + 1] = pbit;
    len = LEN_W'(2 + nd + (cfg.par_en ? 1 : 0) + (cfg.stop2 ? 1 : 0));
  end
endmodule

// File: rtl/uart_frame_tx_subtick.sv
`timescale 1ns/1ps
module uart_frame_tx_subtick #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic restart,
  output logic bit_end
);
  localparam int unsigned CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (active && tick)
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_end = active && tick && (cnt_q == LAST);
endmodule

// File: rtl/uart_frame_tx_shifter.sv
`timescale 1ns/1ps
module uart_frame_tx_shifter
  import uart_frame_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   len,
  input  logic               advance,
  input  logic               brk,
  output logic               active,
  output logic               last,
  output logic               txd
);
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic               act_q, act_d;
  logic               txd_q, txd_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    act_d  = act_q;
    if (load) begin
      sh_d   = frame;
      left_d = len - 1'b1;
      act_d  = 1'b1;
    end else if (advance) begin
      if (left_q == '0) begin
        act_d = 1'b0;
      end else begin
        sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
        left_d = left_q - 1'b1;
      end
    end
    txd_d = act_d ? sh_d[0] : ~brk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      act_q  <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      act_q  <= act_d;
      txd_q  <= txd_d;
    end
  end

  assign active = act_q;
  assign last   = (left_q == '0);
  assign txd    = txd_q;
endmodule

// File: rtl/uart_frame_tx.sv
`timescale 1ns/1ps
module uart_frame_tx
  import uart_frame_tx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              en_global,
  input  logic              en_tx,
  input  logic              cts_flow_en,
  input  logic              cts,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              stop2,
  input  logic              brk,
  input  logic              ch_valid,
  input  logic [DATA_W-1:0] ch_data,
  output logic              ch_ready,
  output logic              txd,
  output logic              busy
);
  line_cfg_t          cfg;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               active, last, bit_end;
  logic               slot_free, start_ok, load;

  assign cfg = '{wlen: wlen, par_en: par_en, par_even: par_even,
                 par_stick: par_stick, stop2: stop2};

  // a new frame may begin when idle or as the final stop bit expires
  assign slot_free = !active || (bit_end && last);
  assign start_ok  = en_global && en_tx && !brk && (!cts_flow_en || cts);
  assign load      = ch_valid && start_ok && baud_tick && slot_free;

  uart_frame_tx_framer u_framer (
    .data  (ch_data),
    .cfg   (cfg),
    .frame (frame),
    .len   (len)
  );

  uart_frame_tx_subtick #(.OVERSAMPLE(OVERSAMPLE)) u_subtick (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .active  (active),
    .restart (load),
    .bit_end (bit_end)
  );

  uart_frame_tx_shifter u_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .frame   (frame),
    .len     (len),
    .advance (bit_end),
    .brk     (brk),
    .active  (active),
    .last    (last),
    .txd     (txd)
  );

  assign ch_ready = load;
  assign busy     = ch_valid || active;
endmodule

// File: rtl/uart_frame_tx_checker.sv
`timescale 1ns/1ps
module uart_frame_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic en_global,
  input logic en_tx,
  input logic cts_flow_en,
  input logic cts,
  input logic brk,
  input logic ch_valid,
  input logic ch_ready,
  input logic txd,
  input logic busy
);
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    ch_ready |=> !txd);

  a_r6_break_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !busy) |=> !txd);

  a_r8_pending_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |-> busy);

  a_r9_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ready && cts_flow_en) |-> cts);

  a_r10_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |=> txd);

  a_r11_take_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    ch_ready |-> (ch_valid && en_global && en_tx && !brk));
endmodule

bind uart_frame_tx uart_frame_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en_global(en_global), .en_tx(en_tx),
  .cts_flow_en(cts_flow_en), .cts(cts), .brk(brk), .ch_valid(ch_valid),
  .ch_ready(ch_ready), .txd(txd), .busy(busy)
);

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, baud_tick, en_global, en_tx, cts_flow_en, cts;
  logic [1:0] wlen;
  logic       par_en, par_even, par_stick, stop2, brk, ch_valid;
  logic [7:0] ch_data;
  logic       ch_ready, txd, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [1:0] tdiv = 2'd0;

  uart_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .en_global(en_global),
    .en_tx(en_tx), .cts_flow_en(cts_flow_en), .cts(cts), .wlen(wlen),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .stop2(stop2), .brk(brk), .ch_valid(ch_valid), .ch_data(ch_data),
    .ch_ready(ch_ready), .txd(txd), .busy(busy)
  );

  // strobe once every 4 clocks, so one bit spans 64 clocks
  always @(posedge clk) begin
    tdiv      <= tdiv + 2'd1;
    baud_tick <= (tdiv == 2'd3);
    cyc       <= cyc + 1;
  end

  always @(posedge clk) begin
    if (cyc == 190000 && !done) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sends one character and checks every bit at its centre
  task automatic send_frame(input logic [7:0] d, input int drop_at, input int brk_at);
    int nd, len, ones, waited;
    logic pbit, e;
    string tag;
    nd = 5 + int'(wlen);
    ones = 0;
    for (int i = 0; i < nd; i++) ones += int'(d[i]);
    pbit = par_stick ? ~par_even : (par_even ? ones[0] : ~ones[0]);
    len = 1 + nd + (par_en ? 1 : 0) + (stop2 ? 2 : 1);
    @(negedge clk);
    ch_data  = d;
    ch_valid = 1'b1;
    waited = 0;
    #1;
    while (!ch_ready && waited < 4000) begin
      @(negedge clk);
      #1;
      waited++;
    end
    chk(waited < 4000, "R11 handshake", waited, 0);
    @(posedge clk);
    @(negedge clk);
    ch_valid = 1'b0;
    repeat (32) @(posedge clk);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == 0) begin
        e = 1'b0; tag = "R1 start";
      end else if (k <= nd) begin
        e = d[k-1]; tag = "R2 data";
      end else if (par_en && k == nd + 1) begin
        e = pbit; tag = par_stick ? "R4 stick parity" : "R3 parity";
      end else begin
        e = 1'b1; tag = (stop2 && k == len - 1) ? "R5 second stop" : "R1 stop";
      end
      if (drop_at >= 0 && k > drop_at) tag = {tag, " R7"};
      if (brk_at >= 0 && k > brk_at) tag = {tag, " R6"};
      chk(txd == e, tag, int'(txd), int'(e));
      if (k == 0) chk(busy == 1'b1, "R8 busy in frame", int'(busy), 1);
      if (k == drop_at) en_tx = 1'b0;
      if (k == brk_at) brk = 1'b1;
      repeat (64) @(posedge clk);
    end
    @(negedge clk);
    chk(txd == ~brk, brk ? "R6 break after frame" : "R10 idle after frame",
        int'(txd), int'(~brk));
    chk(busy == 1'b0, "R8 busy drops", int'(busy), 0);
  endtask

  // holds data pending and checks no frame begins
  task automatic watch_blocked(input string req, input logic exp_txd);
    int seen_ready, bad_txd, bad_busy;
    seen_ready = 0; bad_txd = 0; bad_busy = 0;
    @(negedge clk);
    ch_valid = 1'b1;
    repeat (120) begin
      #1;
      if (ch_ready) seen_ready++;
      @(negedge clk);
      if (txd != exp_txd) bad_txd++;
      if (!busy) bad_busy++;
    end
    chk(seen_ready == 0, {req, " no start"}, seen_ready, 0);
    chk(bad_txd == 0, {req, " line level"}, bad_txd, 0);
    chk(bad_busy == 0, "R8 busy while pending", bad_busy, 0);
    ch_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; en_global = 1'b1; en_tx = 1'b1; cts_flow_en = 1'b0; cts = 1'b0;
    wlen = 2'd3; par_en = 1'b0; par_even = 1'b0; par_stick = 1'b0; stop2 = 1'b0;
    brk = 1'b0; ch_valid = 1'b0; ch_data = 8'h00; baud_tick = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(txd == 1'b1, "R10 reset line", int'(txd), 1);
    chk(busy == 1'b0, "R8 reset busy", int'(busy), 0);
    chk(ch_ready == 1'b0, "R11 reset ready", int'(ch_ready), 0);
    rst_n = 1'b1;

    // every line configuration, cts low with flow control off (R9)
    for (int c = 0; c < 64; c++) begin
      wlen = c[1:0]; par_en = c[2]; par_even = c[3]; par_stick = c[4]; stop2 = c[5];
      send_frame(8'(c * 53 + 29), -1, -1);
    end

    wlen = 2'd3; par_en = 1'b1; par_even = 1'b1; par_stick = 1'b0; stop2 = 1'b0;
    send_frame(8'hFF, -1, -1);
    par_even = 1'b0;
    send_frame(8'h00, -1, -1);

    // R7: transmit enable dropped mid-frame, then each enable low blocks starts
    send_frame(8'hC3, 2, -1);
    watch_blocked("R7 tx off", 1'b1);
    en_tx = 1'b1; en_global = 1'b0;
    watch_blocked("R7 global off", 1'b1);
    en_global = 1'b1;

    // R9: flow control gating
    cts_flow_en = 1'b1; cts = 1'b0;
    watch_blocked("R9 cts low", 1'b1);
    cts = 1'b1;
    send_frame(8'h5E, -1, -1);
    cts_flow_en = 1'b0; cts = 1'b0;

    // R6: break raised mid-frame
    stop2 = 1'b1;
    send_frame(8'h96, 3, 3);
    en_tx = 1'b1;
    watch_blocked("R6 break", 1'b0);
    brk = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R10 line after break", int'(txd), 1);
    send_frame(8'h3C, -1, -1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule